// File: doc/BRIEF.md
# Codec Control Serial Writer

This block turns one register write into a serial frame on a three-wire control port that is shared by two audio codec chips. The chips share a serial clock and a data line. Each chip has its own active-low select. A host presents a chip index, a 5-bit register address and an 8-bit data value, then strobes `start`. The block holds `busy` high while it shifts the frame out, and pulses `done` for one cycle when every line is high again.

The frame is 16 bits long and is sent most significant bit first. Its top two bits carry a fixed chip address. A set bit then marks the frame as a write. The register address and the data byte follow. Every step of the sequence lasts one settling tick of `TICK_CYCLES` clock cycles. These steps are: raising all lines, lowering the select, dropping the clock, setting the data bit, raising the clock, and releasing all lines. The default tick is 100 µs at 125 MHz.

Top module: `codec_ctl_writer`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, and `ser_clk`, `ser_data` and both bits of `sel_n` are 1.
- R2: Frame bit 15 is sent first and bit 0 last. Bits 15:14 hold `CHIP_ADDR` (default 2'b10). Bit 13 is 1. Bits 12:8 hold `reg_addr` and bits 7:0 hold `wr_data`.
- R3: Each frame gives exactly 16 rising edges of `ser_clk` while a select is low. `ser_data` changes only while `ser_clk` is low, so it is stable at every rising edge.
- R4: Chip index 0 lowers only `sel_n[0]` and index 1 lowers only `sel_n[1]`. Both selects are never low at the same time.
- R5: A start with chip index 2 or 3 produces a one-cycle `err` pulse in the cycle after the start edge. `busy` stays low and neither select moves.
- R6: A `start` that arrives while `busy` is high is ignored. The frame in flight is not altered, and no second frame follows it.
- R7: `done` rises exactly 51 × `TICK_CYCLES` cycles after the accepting start edge and lasts one cycle. `busy` is high throughout the frame.
- R8: When `done` is high and between frames, `ser_clk`, `ser_data` and both selects are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one write frame |
| chip_idx | input | 2 | Target codec; only 0 and 1 are valid |
| reg_addr | input | 5 | Codec register address |
| wr_data | input | 8 | Byte to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| err | output | 1 | One-cycle pulse on invalid chip index |
| ser_clk | output | 1 | Shared serial clock, idles high |
| ser_data | output | 1 | Shared serial data, idles high |
| sel_n | output | 2 | Per-codec active-low selects |

## Verification
The bench builds the block with `TICK_CYCLES` set to 3 instead of the default 12500. This makes a whole frame 153 cycles long, so a table of frames to both chips fits in the run. It also puts the exact frame length and the tick-level data setup before each rising clock in reach of cycle counts. A receiving shift register in the bench captures each frame per select. This shows the field layout, and it shows that a start poked in mid-frame changes nothing. Invalid chip indexes are driven directly and checked for the error pulse with quiet selects.

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer #(
  parameter int         TICK_CYCLES = 12500,
  parameter logic [1:0] CHIP_ADDR   = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] chip_idx,
  input  logic [4:0] reg_addr,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       ser_clk,
  output logic       ser_data,
  output logic [1:0] sel_n
);

  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int FW = 16;
  localparam int BW = $clog2(FW);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_SEL, S_LO, S_DAT, S_HI, S_POST
  } step_t;

  step_t          st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic [FW-1:0]  frame_q;
  logic           chip_q;
  logic           data_q;
  logic           done_q;
  logic           err_q;

  wire tick_end = (cnt == CW'(TICK_CYCLES - 1));
  wire sel_on   = (st == S_SEL) || (st == S_LO) || (st == S_DAT) || (st == S_HI);

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign ser_clk  = !((st == S_LO) || (st == S_DAT));
  assign ser_data = data_q;
  assign sel_n    = sel_on ? (chip_q ? 2'b01 : 2'b10) : 2'b11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      frame_q <= '0;
      chip_q  <= 1'b0;
      data_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0;
        if (start) begin
          if (chip_idx[1]) begin
            err_q <= 1'b1;
          end else begin
            frame_q <= {CHIP_ADDR, 1'b1, reg_addr, wr_data};
            chip_q  <= chip_idx[0];
            bidx    <= BW'(FW - 1);
            st      <= S_PRE;
          end
        end
      end else if (!tick_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_PRE: st <= S_SEL;
          S_SEL: st <= S_LO;
          S_LO: begin
            data_q <= frame_q[bidx];
            st     <= S_DAT;
          end
          S_DAT: st <= S_HI;
          S_HI: begin
            if (bidx == '0) begin
              data_q <= 1'b1;
              st     <= S_POST;
            end else begin
              bidx <= bidx - 1'b1;
              st   <= S_LO;
            end
          end
          S_POST: begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  // R4
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n != 2'b00);

  // R5
  bad_chip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sel_n == 2'b11) && !busy);

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(frame_q) && busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ser_clk && ser_data && (sel_n == 2'b11) && !busy);

endmodule

// File: tb/codec_ctl_writer_bench.sv
module codec_ctl_writer_bench;
  localparam int TICK = 3;
  localparam int FRAME_CYC = 51 * TICK;
  localparam int NV = 6;
  // {chip[1:0], addr[4:0], data[7:0]}
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 5'h00, 8'h00},
    {2'd1, 5'h1F, 8'hFF},
    {2'd0, 5'h02, 8'hA5},
    {2'd1, 5'h03, 8'h5A},
    {2'd0, 5'h15, 8'h81},
    {2'd1, 5'h0A, 8'h3C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] chip_idx = '0;
  logic [4:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, err, ser_clk, ser_data;
  logic [1:0] sel_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] rx0, rx1;
  int n0, n1, f0, f1, errp;

  always #4 clk = ~clk;

  codec_ctl_writer #(.TICK_CYCLES(TICK)) u_codec_ctl_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_idx(chip_idx),
    .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .err(err), .ser_clk(ser_clk), .ser_data(ser_data), .sel_n(sel_n)
  );

  always @(posedge ser_clk) begin
    if (!sel_n[0]) begin rx0 = {rx0[14:0], ser_data}; n0++; end
    if (!sel_n[1]) begin rx1 = {rx1[14:0], ser_data}; n1++; end
  end
  always @(negedge sel_n[0]) f0++;
  always @(negedge sel_n[1]) f1++;
  always @(posedge clk) if (err) errp++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx0 = '0; rx1 = '0; n0 = 0; n1 = 0; f0 = 0; f1 = 0; errp = 0;
  endtask

  task automatic run_frame(input logic [1:0] c, input logic [4:0] a,
                           input logic [7:0] d, input bit poke);
    int j;
    bit busy_drop;
    logic [15:0] exp_f;
    logic [15:0] got;
    exp_f = {2'b10, 1'b1, a, d};
    clear_mon();
    busy_drop = 0;
    @(negedge clk);
    chip_idx = c; reg_addr = a; wr_data = d; start = 1'b1;
    j = 0;
    forever begin
      @(negedge clk);
      start = poke && (j == 40);
      if (start) begin chip_idx = {1'b0, ~c[0]}; reg_addr = ~a; wr_data = ~d; end
      if (done) break;
      if (!busy) busy_drop = 1;
      j++;
      if (j > 2000) break;
    end
    got = c[0] ? rx1 : rx0;
    check(got == exp_f, "R2 frame content", got, exp_f);
    check((c[0] ? n1 : n0) == 16, "R3 rising edges", c[0] ? n1 : n0, 16);
    check((c[0] ? f0 : f1) == 0, "R4 other select idle", c[0] ? f0 : f1, 0);
    check((c[0] ? f1 : f0) == 1, "R4 own select once", c[0] ? f1 : f0, 1);
    check(j == FRAME_CYC, "R7 frame length", j, FRAME_CYC);
    check(!busy_drop, "R7 busy held", busy_drop, 0);
    check(ser_clk && ser_data && sel_n == 2'b11, "R8 lines high at done",
          {ser_clk, ser_data, sel_n}, 4'hF);
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
    if (poke) begin
      repeat (FRAME_CYC + 10) @(negedge clk);
      check(!busy && f0 + f1 == 1, "R6 no second frame", f0 + f1, 1);
      check(got == exp_f, "R6 frame unaltered", got, exp_f);
    end
  endtask

  task automatic bad_chip(input logic [1:0] c);
    clear_mon();
    @(negedge clk);
    chip_idx = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err, "R5 err pulse", err, 1);
    check(!busy, "R5 busy low", busy, 0);
    @(negedge clk);
    check(!err && errp == 1, "R5 err one cycle", errp, 1);
    repeat (10) @(negedge clk);
    check(f0 == 0 && f1 == 0 && sel_n == 2'b11, "R5 selects quiet", {f0[3:0], f1[3:0]}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
    check(ser_clk && ser_data && sel_n == 2'b11, "R1 lines high",
          {ser_clk, ser_data, sel_n}, 4'hF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][14:13], VEC[i][12:8], VEC[i][7:0], 1'b0);
    run_frame(2'd0, 5'h11, 8'hC3, 1'b1);
    run_frame(2'd1, 5'h04, 8'h96, 1'b1);
    bad_chip(2'd2);
    bad_chip(2'd3);
    repeat (5) @(negedge clk);
    check(ser_clk && ser_data && sel_n == 2'b11 && !busy, "R8 idle between frames",
          {ser_clk, ser_data, sel_n}, 4'hF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule